// File: doc/BRIEF.md
# Coherent Two-Byte Position Readout Latch

This block sits between a 16-bit position counter and an 8-bit processor bus. A holding register copies the counter on every rising clock edge. A processor reads that copy one byte at a time, and the two reads can be many clocks apart. While the counter keeps moving, the two bytes would normally come from different samples. To prevent this, a small read sequencer freezes the holding register at the start of a read and releases it only when the read is complete. The high byte and the low byte that are returned therefore always belong to the same sample.

The processor starts a read by driving the active-low enable low with the byte select low, which selects the high byte. It then raises the byte select to read the low byte, and finally releases the enable. Once the hold ends, the register follows the counter again. The counting logic and any pad-level tri-state driver sit outside this block. When the enable is released, the data output is driven to zero.

When the counter wraps, software works out relative motion from successive readings. For that result to be unambiguous, software must read at least once per half range of the counter.

Top module: `pos_readout`

## Requirements
- R1: When `rst` is high, the holding register is cleared to zero and the sequencer returns to idle without waiting for a clock edge. While `rst` is high, `data_out` reads zero for both byte selects.
- R2: When no read is in progress, the holding register loads `count_in` on every rising edge of `clk`.
- R3: A read starts on a rising edge where `rd_en_n`=0 and `byte_sel`=0. That edge still loads `count_in`, and the register is frozen from that edge onward.
- R4: During a read, the register keeps its value while `count_in` changes, for both byte selects and for any number of cycles.
- R5: The hold ends on the first rising edge where `rd_en_n`=1 after a low-byte read (`rd_en_n`=0 with `byte_sel`=1) within the same read. No load happens at that edge. Loading resumes from the next edge.
- R6: With `rd_en_n`=0, `data_out` equals bits 15:8 of the register when `byte_sel`=0, and bits 7:0 when `byte_sel`=1. With `rd_en_n`=1, `data_out` is zero.
- R7: If a high-byte access (`rd_en_n`=0, `byte_sel`=0) occurs again while the hold is active, the frozen value is kept and no new load occurs.
- R8: Releasing `rd_en_n` after reading only the high byte does not end the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high clear |
| count_in | input | 16 | Live position count |
| rd_en_n | input | 1 | Active-low read enable |
| byte_sel | input | 1 | 0 selects the high byte, 1 selects the low byte |
| data_out | output | 8 | Selected byte, or zero when not enabled |

## Verification
The assertions assume that `rd_en_n` and `byte_sel` are stable around each rising edge, and that a processor reads the high byte before the low byte. The bench changes these inputs, and `count_in`, only on falling edges, which meets that assumption. It also makes `count_in` differ on every edge of a read, so that any unwanted load shows up as a wrong byte. The sweep runs over walking-one patterns and over all-zero, all-one and mixed patterns.

// File: rtl/pos_readout_pkg.sv
package pos_readout_pkg;
    localparam int POS_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_HIGH = 2'd1,
        RD_LOW  = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic en;
        logic sel_low;
    } bus_req_t;

    function automatic logic [BYTE_W-1:0] pick_byte(
        input logic [POS_W-1:0] word,
        input logic             sel_low
    );
        return sel_low ? word[BYTE_W-1:0] : word[POS_W-1:POS_W-BYTE_W];
    endfunction
endpackage

// File: rtl/rd_sequencer.sv
module rd_sequencer
    import pos_readout_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     hold
);
    rd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (req.en && !req.sel_low) state_d = RD_HIGH;
            RD_HIGH: if (req.en && req.sel_low)  state_d = RD_LOW;
            RD_LOW: begin
                if (!req.en)           state_d = RD_IDLE;
                else if (!req.sel_low) state_d = RD_HIGH;
            end
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= RD_IDLE;
        else     state_q <= state_d;
    end

    assign hold = (state_q != RD_IDLE);

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (!hold && req.en && !req.sel_low) |=> hold);
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == RD_LOW && !req.en) |=> !hold);
    assert_high_only_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == RD_HIGH && !req.en) |=> hold);
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && req.en && !req.sel_low) |=> hold);
endmodule

// File: rtl/pos_latch.sv
module pos_latch
    import pos_readout_pkg::*;
#(
    parameter int W = POS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)       q <= '0;
        else if (!hold) q <= din;
    end

    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));
    assert_track_R2: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (q == $past(din)));
endmodule

// File: rtl/byte_mux.sv
module byte_mux
    import pos_readout_pkg::*;
(
    input  logic [POS_W-1:0]  word,
    input  bus_req_t          req,
    output logic [BYTE_W-1:0] dout
);
    always_comb begin
        dout = '0;
        if (req.en) dout = pick_byte(word, req.sel_low);
    end
endmodule

// File: rtl/pos_readout.sv
module pos_readout
    import pos_readout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [POS_W-1:0]  count_in,
    input  logic              rd_en_n,
    input  logic              byte_sel,
    output logic [BYTE_W-1:0] data_out
);
    bus_req_t         req;
    logic             hold;
    logic [POS_W-1:0] held_word;

    assign req.en      = !rd_en_n;
    assign req.sel_low = byte_sel;

    rd_sequencer u_seq (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .hold (hold)
    );

    pos_latch #(.W(POS_W)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .din  (count_in),
        .q    (held_word)
    );

    byte_mux u_mux (
        .word (held_word),
        .req  (req),
        .dout (data_out)
    );

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        rd_en_n |-> (data_out == '0));
endmodule

// File: tb/pos_readout_test.sv
module pos_readout_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] count_in = 16'h0000;
    logic        rd_en_n = 1'b1;
    logic        byte_sel = 1'b0;
    logic [7:0]  data_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pos_readout uut (
        .clk(clk), .rst(rst), .count_in(count_in),
        .rd_en_n(rd_en_n), .byte_sel(byte_sel), .data_out(data_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic full_read(input logic [15:0] v);
        logic [15:0] w;
        w = v ^ 16'h0F0F;
        @(negedge clk); count_in = v; rd_en_n = 0; byte_sel = 0;
        @(negedge clk); chk("R3 start capture high byte", data_out, v[15:8]);
        count_in = ~v;
        @(negedge clk); chk("R4 high byte frozen", data_out, v[15:8]);
        byte_sel = 1; count_in = v + 16'h1234;
        #1 chk("R6 low byte select", data_out, v[7:0]);
        @(negedge clk); chk("R4 low byte frozen", data_out, v[7:0]);
        rd_en_n = 1;
        #1 chk("R6 disabled output zero", data_out, 8'h00);
        @(negedge clk); count_in = w; rd_en_n = 0; byte_sel = 1;
        #1 chk("R5 no load on release edge", data_out, v[7:0]);
        @(negedge clk); chk("R5 tracking resumes", data_out, w[7:0]);
        rd_en_n = 1;
    endtask

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        // R1: reset clears, even with a read requested
        rd_en_n = 0; byte_sel = 0; count_in = 16'hBEEF;
        repeat (3) @(negedge clk);
        chk("R1 reset high byte", data_out, 8'h00);
        byte_sel = 1; #1 chk("R1 reset low byte", data_out, 8'h00);
        rd_en_n = 1; rst = 0;

        // R2: tracking with low-byte reads that do not start a hold
        @(negedge clk); rd_en_n = 0; byte_sel = 1;
        for (int i = 0; i < 16; i++) begin
            count_in = 16'h0101 * i[15:0] + 16'h0037;
            @(negedge clk);
            chk("R2 idle tracking", data_out, 8'h01 * i[7:0] + 8'h37);
        end
        rd_en_n = 1;

        // sweep of full reads
        for (int b = 0; b < 16; b++) full_read(16'h0001 << b);
        full_read(16'h0000); full_read(16'hFFFF);
        full_read(16'hA5C3); full_read(16'h5A3C);

        // R7: high-byte access again during hold
        @(negedge clk); count_in = 16'h1357; rd_en_n = 0; byte_sel = 0;
        @(negedge clk); count_in = 16'h2468; byte_sel = 1;
        @(negedge clk); count_in = 16'h9999; byte_sel = 0;
        @(negedge clk); chk("R7 restart keeps high byte", data_out, 8'h13);
        count_in = 16'h7777; byte_sel = 1;
        @(negedge clk); chk("R7 restart keeps low byte", data_out, 8'h57);
        rd_en_n = 1;
        @(negedge clk); @(negedge clk);

        // R8: release after high byte only keeps the hold
        @(negedge clk); count_in = 16'hC0DE; rd_en_n = 0; byte_sel = 0;
        @(negedge clk); rd_en_n = 1; count_in = 16'h1111;
        @(negedge clk); count_in = 16'h2222;
        @(negedge clk); count_in = 16'h3333; rd_en_n = 0; byte_sel = 1;
        @(negedge clk); chk("R8 hold survives high-only read", data_out, 8'hDE);
        rd_en_n = 1;
        @(negedge clk); count_in = 16'h4455; rd_en_n = 0; byte_sel = 1;
        @(negedge clk); chk("R5 resumed after low read", data_out, 8'h55);

        // R1: asynchronous clear mid-hold
        rd_en_n = 0; byte_sel = 0; count_in = 16'hABCD;
        @(negedge clk); chk("R3 capture before reset", data_out, 8'hAB);
        #1 rst = 1;
        #0.5 chk("R1 async clear", data_out, 8'h00);
        @(negedge clk); rst = 0; rd_en_n = 1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule